// File: doc/BRIEF.md
# Cable Reflectometry Test Sequencer

This block times a reflectometry cable test on a single-pair Ethernet line. It is set up through a small register set: a two-bit code for each of the two quiet windows, a transmission length in microseconds, an amplitude choice and the correlation tap window. A write of the go bit then runs a fixed timeline. First the line is held quiet. Then a modulated probe is driven while `tx_en` is high. A second quiet window follows, and after it the block hands the line over to forced-link operation by raising `force_link`.

Timing is counted on a one-microsecond tick input. A quiet-window code selects 0, 10, 100 or 1000 milliseconds, and each millisecond is `TICKS_PER_MS` ticks. An external echo correlator supplies a peak flag, a peak polarity and a peak position. When the probe ends these values are latched and decoded into a verdict: intact, open or short. If the far end is heard talking while the block is listening or probing, the test stops at once and reports a failure.

Top module: `cabletest_seq`

## Requirements
- R1: After reset the duration register (address 2) reads 16000. The tap register (address 3) reads start 4 in bits [6:0] and end 36 in bits [14:8]. The control register (address 0), the timing register (address 1) and the result register (address 4) read 0. `tx_en`, `force_link` and `amp_hi` are low, and `tap_start` = 4, `tap_end` = 36.
- R2: An accepted go runs the phases strictly in order: quiet (`tx_en` low), probe (`tx_en` high), quiet, then `force_link` goes high and stays high until the next go.
- R3: Timing register bits [1:0] code the first quiet window and bits [3:2] code the second. Codes 0/1/2/3 mean 0/10/100/1000 ms, and one ms is `TICKS_PER_MS` ticks. A non-zero window ends on its last counted tick. A zero window takes exactly one clock cycle.
- R4: The probe lasts exactly as many ticks as the duration register (address 2, 16 bits, in microseconds).
- R5: Output `amp_hi` equals timing register bit 12 (0 selects the 1 V level, 1 selects the 2.4 V level).
- R6: When the probe ends, control bit 1 (done) sets. At the same time the echo inputs are latched into the result register: bit 11 holds the peak flag, bit 10 the peak sign and bits [9:0] the location.
- R7: The verdict is reported on `verdict` and in result bits [13:12]. It is 0 when no peak was found, 2 (open) when the peak sign is 1, 1 (short) when the peak sign is 0, and 3 after a failed test.
- R8: `line_active` seen during the first quiet window or the probe ends the test. Done and fail (control bit 0) both set and `tx_en` drops on the next edge. `force_link` does not rise, and the latched result stays zero.
- R9: `line_active` has no effect during the second quiet window or while the block is idle or in forced-link operation.
- R10: Control bit 15 (go) always reads 0. A go written while a test is in progress is ignored and does not alter the running timeline.
- R11: Done, fail and the result fields hold their values until the next accepted go, and that go clears them.
- R12: Tap register fields [6:0] and [14:8] drive `tap_start` and `tap_end` and read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle pulse each microsecond |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| line_active | input | 1 | Activity seen on the line |
| echo_peak | input | 1 | Correlator found a reflection peak |
| echo_sign | input | 1 | Polarity of the reflection peak |
| echo_loc | input | 10 | Position of the reflection peak |
| tx_en | output | 1 | Drive the modulated probe |
| amp_hi | output | 1 | Probe amplitude select |
| force_link | output | 1 | Hand-over to forced-link operation |
| tap_start | output | 7 | First correlation tap index |
| tap_end | output | 7 | Last correlation tap index |
| verdict | output | 2 | Decoded cable verdict |

## Verification
The timeline is checked directly with all-zero window codes and a one-tick probe, which shows that zero-length phases take one cycle each. It is also checked with a long first window and a short second one, which shows that the two codes are applied to the right windows. Random codes, durations and tick densities then compare the tick count of each phase with the decoded window lengths, so a counter that is off by one or that counts cycles instead of ticks gives a wrong count. Line activity is injected in each of the three timed phases, which separates the phases that abort from the phase that ignores it. Echo patterns with no peak, a positive peak and a negative peak tell the three verdicts apart, and a go written mid-run and echo changes after completion show whether the running state and the latched state are protected.

// File: rtl/cts_pkg.sv
package cts_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_PRE,
      PH_TX,
      PH_POST,
      PH_LINK
   } phase_e;

   localparam logic [2:0] A_CTRL = 3'd0;
   localparam logic [2:0] A_TIME = 3'd1;
   localparam logic [2:0] A_DUR  = 3'd2;
   localparam logic [2:0] A_TAP  = 3'd3;
   localparam logic [2:0] A_RES  = 3'd4;

   localparam int CTRL_GO   = 15;
   localparam int CTRL_DONE = 1;
   localparam int CTRL_FAIL = 0;
   localparam int TIME_AMP  = 12;

   localparam logic [1:0] V_OK    = 2'd0;
   localparam logic [1:0] V_SHORT = 2'd1;
   localparam logic [1:0] V_OPEN  = 2'd2;
   localparam logic [1:0] V_NONE  = 2'd3;

   function automatic int unsigned silence_ms(input logic [1:0] code);
      case (code)
         2'd0:    return 0;
         2'd1:    return 10;
         2'd2:    return 100;
         default: return 1000;
      endcase
   endfunction

endpackage

// File: rtl/cts_timer.sv
module cts_timer #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          tick,
   output logic          expire
);

   logic [CW-1:0] rem_q;

   assign expire = (rem_q == '0) || (tick && (rem_q == CW'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rem_q <= '0;
      else if (load)
         rem_q <= load_val;
      else if (tick && (rem_q != '0))
         rem_q <= rem_q - CW'(1);
   end

   // R4
   no_climb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load) |-> (rem_q <= $past(rem_q)));

endmodule

// File: rtl/cts_ctrl.sv
module cts_ctrl
   import cts_pkg::*;
#(
   parameter int CW           = 16,
   parameter int TICKS_PER_MS = 1000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic          line_active,
   input  logic          expire,
   input  logic [1:0]    pre_code,
   input  logic [1:0]    post_code,
   input  logic [15:0]   dur,
   output logic          load,
   output logic [CW-1:0] load_val,
   output logic          tx_en,
   output logic          force_link,
   output logic          clear,
   output logic          set_done,
   output logic          set_fail,
   output logic          capture
);

   phase_e state, nxt;
   logic [CW-1:0] pre_ticks, post_ticks;

   assign pre_ticks  = CW'(silence_ms(pre_code) * TICKS_PER_MS);
   assign post_ticks = CW'(silence_ms(post_code) * TICKS_PER_MS);

   always_comb begin
      nxt      = state;
      load     = 1'b0;
      load_val = '0;
      clear    = 1'b0;
      set_done = 1'b0;
      set_fail = 1'b0;
      capture  = 1'b0;
      case (state)
         PH_IDLE, PH_LINK: if (go) begin
            nxt      = PH_PRE;
            load     = 1'b1;
            load_val = pre_ticks;
            clear    = 1'b1;
         end
         PH_PRE: if (line_active) begin
            nxt      = PH_IDLE;
            set_done = 1'b1;
            set_fail = 1'b1;
         end else if (expire) begin
            nxt      = PH_TX;
            load     = 1'b1;
            load_val = CW'(dur);
         end
         PH_TX: if (line_active) begin
            nxt      = PH_IDLE;
            set_done = 1'b1;
            set_fail = 1'b1;
         end else if (expire) begin
            nxt      = PH_POST;
            load     = 1'b1;
            load_val = post_ticks;
            capture  = 1'b1;
            set_done = 1'b1;
         end
         PH_POST: if (expire) nxt = PH_LINK;
         default: nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= PH_IDLE;
      else        state <= nxt;
   end

   assign tx_en      = (state == PH_TX);
   assign force_link = (state == PH_LINK);

   // R10
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == PH_PRE || state == PH_TX || state == PH_POST) && go && !line_active && !expire)
      |=> (state == $past(state)));

   // R8
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == PH_PRE || state == PH_TX) && line_active) |=> (state == PH_IDLE));

   // R2
   order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(force_link) |-> ($past(state) == PH_POST));

   // R9
   post_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PH_POST && line_active && !expire) |=> (state == PH_POST));

endmodule

// File: rtl/cts_regs.sv
module cts_regs
   import cts_pkg::*;
#(
   parameter int TAP_W           = 7,
   parameter int LOC_W           = 10,
   parameter int DUR_RESET       = 16000,
   parameter int TAP_START_RESET = 4,
   parameter int TAP_END_RESET   = 36
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [15:0]      wr_data,
   input  logic [2:0]       rd_addr,
   output logic [15:0]      rd_data,
   output logic             go,
   output logic [1:0]       pre_code,
   output logic [1:0]       post_code,
   output logic             amp_hi,
   output logic [15:0]      dur,
   output logic [TAP_W-1:0] tap_start,
   output logic [TAP_W-1:0] tap_end,
   input  logic             clear,
   input  logic             set_done,
   input  logic             set_fail,
   input  logic             capture,
   input  logic             echo_peak,
   input  logic             echo_sign,
   input  logic [LOC_W-1:0] echo_loc,
   output logic [1:0]       verdict
);

   logic             done_q, fail_q, peak_q, sign_q;
   logic [LOC_W-1:0] loc_q;
   logic [15:0]      res_word, time_word, tap_word;

   assign go = wr_en && (wr_addr == A_CTRL) && wr_data[CTRL_GO];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_code  <= '0;
         post_code <= '0;
         amp_hi    <= 1'b0;
         dur       <= 16'(DUR_RESET);
         tap_start <= TAP_W'(TAP_START_RESET);
         tap_end   <= TAP_W'(TAP_END_RESET);
      end else if (wr_en) begin
         case (wr_addr)
            A_TIME: begin
               pre_code  <= wr_data[1:0];
               post_code <= wr_data[3:2];
               amp_hi    <= wr_data[TIME_AMP];
            end
            A_DUR: dur <= wr_data;
            A_TAP: begin
               tap_start <= wr_data[TAP_W-1:0];
               tap_end   <= wr_data[8 +: TAP_W];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         fail_q <= 1'b0;
         peak_q <= 1'b0;
         sign_q <= 1'b0;
         loc_q  <= '0;
      end else if (clear) begin
         done_q <= 1'b0;
         fail_q <= 1'b0;
         peak_q <= 1'b0;
         sign_q <= 1'b0;
         loc_q  <= '0;
      end else begin
         if (set_done) done_q <= 1'b1;
         if (set_fail) fail_q <= 1'b1;
         if (capture) begin
            peak_q <= echo_peak;
            sign_q <= echo_sign;
            loc_q  <= echo_loc;
         end
      end
   end

   always_comb begin
      if (fail_q)       verdict = V_NONE;
      else if (!peak_q) verdict = V_OK;
      else if (sign_q)  verdict = V_OPEN;
      else              verdict = V_SHORT;
   end

   always_comb begin
      res_word           = '0;
      res_word[LOC_W-1:0] = loc_q;
      res_word[10]       = sign_q;
      res_word[11]       = peak_q;
      res_word[13:12]    = verdict;
      time_word          = '0;
      time_word[1:0]     = pre_code;
      time_word[3:2]     = post_code;
      time_word[TIME_AMP] = amp_hi;
      tap_word           = '0;
      tap_word[TAP_W-1:0] = tap_start;
      tap_word[8 +: TAP_W] = tap_end;
      case (rd_addr)
         A_CTRL:  rd_data = {14'd0, done_q, fail_q};
         A_TIME:  rd_data = time_word;
         A_DUR:   rd_data = dur;
         A_TAP:   rd_data = tap_word;
         A_RES:   rd_data = res_word;
         default: rd_data = '0;
      endcase
   end

   // R8
   fail_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail_q |-> done_q);

   // R11
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !clear) |=> (done_q && $stable(loc_q) && $stable(peak_q) && $stable(sign_q)));

   // R6
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(done_q) && !fail_q) |-> (loc_q == $past(echo_loc) && peak_q == $past(echo_peak)
                                       && sign_q == $past(echo_sign)));

endmodule

// File: rtl/cabletest_seq.sv
module cabletest_seq #(
   parameter int TICKS_PER_MS    = 1000,
   parameter int DUR_RESET       = 16000,
   parameter int TAP_W           = 7,
   parameter int LOC_W           = 10,
   parameter int TAP_START_RESET = 4,
   parameter int TAP_END_RESET   = 36
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_us,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [15:0]      wr_data,
   input  logic [2:0]       rd_addr,
   output logic [15:0]      rd_data,
   input  logic             line_active,
   input  logic             echo_peak,
   input  logic             echo_sign,
   input  logic [LOC_W-1:0] echo_loc,
   output logic             tx_en,
   output logic             amp_hi,
   output logic             force_link,
   output logic [TAP_W-1:0] tap_start,
   output logic [TAP_W-1:0] tap_end,
   output logic [1:0]       verdict
);

   localparam int MAX_SIL = 1000 * TICKS_PER_MS;
   localparam int SIL_W   = $clog2(MAX_SIL + 1);
   localparam int CW      = (SIL_W > 16) ? SIL_W : 16;

   if (LOC_W < 1 || LOC_W > 10) begin : g_loc_bad
      $error("LOC_W must lie in 1..10");
   end
   if (TAP_W < 1 || TAP_W > 7) begin : g_tap_bad
      $error("TAP_W must lie in 1..7");
   end
   if (TICKS_PER_MS < 1) begin : g_tpm_bad
      $error("TICKS_PER_MS must be positive");
   end

   logic          go, load, expire, clear, set_done, set_fail, capture;
   logic [CW-1:0] load_val;
   logic [1:0]    pre_code, post_code;
   logic [15:0]   dur;

   cts_regs #(
      .TAP_W(TAP_W), .LOC_W(LOC_W), .DUR_RESET(DUR_RESET),
      .TAP_START_RESET(TAP_START_RESET), .TAP_END_RESET(TAP_END_RESET)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .go(go), .pre_code(pre_code),
      .post_code(post_code), .amp_hi(amp_hi), .dur(dur), .tap_start(tap_start),
      .tap_end(tap_end), .clear(clear), .set_done(set_done), .set_fail(set_fail),
      .capture(capture), .echo_peak(echo_peak), .echo_sign(echo_sign),
      .echo_loc(echo_loc), .verdict(verdict)
   );

   cts_ctrl #(.CW(CW), .TICKS_PER_MS(TICKS_PER_MS)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .go(go), .line_active(line_active), .expire(expire),
      .pre_code(pre_code), .post_code(post_code), .dur(dur), .load(load),
      .load_val(load_val), .tx_en(tx_en), .force_link(force_link), .clear(clear),
      .set_done(set_done), .set_fail(set_fail), .capture(capture)
   );

   cts_timer #(.CW(CW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
      .tick(tick_us), .expire(expire)
   );

endmodule

// File: tb/test_cabletest_seq.sv
module test_cabletest_seq;

   localparam int TPM = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_us = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        line_active = 1'b0;
   logic        echo_peak = 1'b0;
   logic        echo_sign = 1'b0;
   logic [9:0]  echo_loc = '0;
   logic        tx_en, amp_hi, force_link;
   logic [6:0]  tap_start, tap_end;
   logic [1:0]  verdict;

   int checks = 0;
   int errors = 0;
   int tick_pct = 100;
   bit mon_arm = 1'b0;
   int ph_m = 0;
   int pre_tk, pre_cy, tx_tk, tx_cy, post_tk, post_cy;

   always #4 clk = ~clk;

   cabletest_seq #(.TICKS_PER_MS(TPM)) i_cabletest_seq (
      .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .line_active(line_active),
      .echo_peak(echo_peak), .echo_sign(echo_sign), .echo_loc(echo_loc), .tx_en(tx_en),
      .amp_hi(amp_hi), .force_link(force_link), .tap_start(tap_start), .tap_end(tap_end),
      .verdict(verdict)
   );

   // phase monitor: outputs are stable at the falling edge; tick is driven here
   always @(negedge clk) begin : mon
      bit t_now;
      t_now = ($urandom_range(99) < 32'(tick_pct));
      case (ph_m)
         1: if (tx_en) begin ph_m = 2; tx_tk += int'(t_now); tx_cy++; end
            else begin pre_tk += int'(t_now); pre_cy++; end
         2: if (tx_en) begin tx_tk += int'(t_now); tx_cy++; end
            else if (force_link) ph_m = 4;
            else begin ph_m = 3; post_tk += int'(t_now); post_cy++; end
         3: if (force_link) ph_m = 4;
            else begin post_tk += int'(t_now); post_cy++; end
         default: ;
      endcase
      if (mon_arm) begin
         ph_m = 1; pre_tk = 0; pre_cy = 0; tx_tk = 0; tx_cy = 0; post_tk = 0; post_cy = 0;
      end
      tick_us = t_now;
   end

   function automatic int sil(input logic [1:0] c);
      case (c)
         2'd0: return 0;
         2'd1: return 10 * TPM;
         2'd2: return 100 * TPM;
         default: return 1000 * TPM;
      endcase
   endfunction

   function automatic logic [1:0] exp_verdict(input bit fl, input bit pk, input bit sg);
      if (fl) return 2'd3;
      if (!pk) return 2'd0;
      return sg ? 2'd2 : 2'd1;
   endfunction

   function automatic logic [15:0] exp_res(input bit pk, input bit sg, input logic [9:0] lc);
      return {2'b00, exp_verdict(1'b0, pk, sg), pk, sg, lc};
   endfunction

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      rd_addr = a; #1; d = rd_data; rd_addr = '0;
   endtask

   task automatic go_run(input bit arm);
      mon_arm = arm;
      wr(3'd0, 16'h8000);
      mon_arm = 1'b0;
   endtask

   task automatic wait_link(input int lim);
      for (int n = 0; n < lim && !force_link; n++) step();
   endtask

   task automatic setup(input logic [1:0] pre, input logic [1:0] post, input logic [15:0] dur,
                        input bit amp);
      wr(3'd1, {3'b000, amp, 8'h00, post, pre});
      wr(3'd2, dur);
   endtask

   task automatic check_timeline(input logic [1:0] pre, input logic [1:0] post, input int dur);
      if (sil(pre) == 0) chk(pre_cy == 1, "R3", "zero first window cycles", pre_cy, 1);
      else chk(pre_tk == sil(pre), "R3", "first window ticks", pre_tk, sil(pre));
      chk(tx_tk == dur, "R4", "probe ticks", tx_tk, dur);
      if (sil(post) == 0) chk(post_cy == 1, "R3", "zero second window cycles", post_cy, 1);
      else chk(post_tk == sil(post), "R3", "second window ticks", post_tk, sil(post));
      chk(force_link == 1'b1 && tx_cy > 0, "R2", "forced link after ordered phases",
          int'(force_link), 1);
   endtask

   task automatic run(input logic [1:0] pre, input logic [1:0] post, input logic [15:0] dur,
                      input bit amp, input bit pk, input bit sg, input logic [9:0] lc, input int pct);
      logic [15:0] d;
      setup(pre, post, dur, amp);
      chk(amp_hi == amp, "R5", "amplitude select", int'(amp_hi), int'(amp));
      echo_peak = pk; echo_sign = sg; echo_loc = lc; tick_pct = pct;
      go_run(1'b1);
      rd(3'd0, d);
      chk(d == 16'h0000, "R10", "go bit reads zero, status cleared", int'(d), 0);
      wait_link(40000);
      check_timeline(pre, post, int'(dur));
      rd(3'd4, d);
      chk(d == exp_res(pk, sg, lc), "R6", "latched result word", int'(d), int'(exp_res(pk, sg, lc)));
      chk(verdict == exp_verdict(1'b0, pk, sg), "R7", "verdict port", int'(verdict),
          int'(exp_verdict(1'b0, pk, sg)));
      rd(3'd0, d);
      chk(d == 16'h0002, "R6", "done without fail", int'(d), 2);
   endtask

   initial begin : main
      logic [15:0] d;
      void'($urandom(32'd20611));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();

      // reset state
      rd(3'd2, d); chk(d == 16'd16000, "R1", "duration reset", int'(d), 16000);
      rd(3'd3, d); chk(d == 16'h2404, "R1", "tap reset", int'(d), 16'h2404);
      rd(3'd0, d); chk(d == 16'h0000, "R1", "control reset", int'(d), 0);
      rd(3'd1, d); chk(d == 16'h0000, "R1", "timing reset", int'(d), 0);
      rd(3'd4, d); chk(d == 16'h0000, "R1", "result reset", int'(d), 0);
      chk(!tx_en && !force_link && !amp_hi, "R1", "outputs idle",
          int'({tx_en, force_link, amp_hi}), 0);
      chk(tap_start == 7'd4 && tap_end == 7'd36, "R1", "tap outputs",
          int'({tap_end, tap_start}), int'({7'd36, 7'd4}));

      // R12 tap window
      wr(3'd3, {1'b0, 7'd100, 1'b0, 7'd9});
      chk(tap_start == 7'd9 && tap_end == 7'd100, "R12", "tap outputs",
          int'({tap_end, tap_start}), int'({7'd100, 7'd9}));
      rd(3'd3, d); chk(d == 16'h6409, "R12", "tap readback", int'(d), 16'h6409);

      // directed: zero windows, one-tick probe, no peak
      run(2'd0, 2'd0, 16'd1, 1'b0, 1'b0, 1'b0, 10'd0, 100);
      // directed: open fault, high amplitude
      run(2'd1, 2'd2, 16'd5, 1'b1, 1'b1, 1'b1, 10'h3FF, 100);
      // directed: short fault
      run(2'd2, 2'd1, 16'd7, 1'b0, 1'b1, 1'b0, 10'd300, 60);

      // R11 hold after done, then clear by new go
      echo_peak = 1'b0; echo_sign = 1'b1; echo_loc = 10'd5;
      repeat (10) step();
      rd(3'd4, d);
      chk(d == exp_res(1'b1, 1'b0, 10'd300), "R11", "result held after done", int'(d),
          int'(exp_res(1'b1, 1'b0, 10'd300)));
      setup(2'd3, 2'd0, 16'd1, 1'b0);
      go_run(1'b1);
      rd(3'd0, d); chk(d == 16'h0000, "R11", "go clears done", int'(d), 0);
      rd(3'd4, d); chk(d == 16'h0000, "R11", "go clears result", int'(d), 0);
      wait_link(10000);
      check_timeline(2'd3, 2'd0, 1);

      // R10 go while busy
      setup(2'd1, 2'd0, 16'd30, 1'b0);
      go_run(1'b1);
      while (!tx_en) step();
      repeat (5) step();
      go_run(1'b0);
      wait_link(2000);
      chk(tx_tk == 30 && pre_tk == 20, "R10", "busy go ignored (probe ticks)", tx_tk, 30);

      // R9 line activity in second window and in link state
      setup(2'd0, 2'd1, 16'd3, 1'b0);
      go_run(1'b1);
      while (!tx_en) step();
      while (tx_en) step();
      step();
      line_active = 1'b1; step(); line_active = 1'b0;
      wait_link(2000);
      rd(3'd0, d);
      chk(force_link && d == 16'h0002, "R9", "activity in second window ignored", int'(d), 2);
      line_active = 1'b1; repeat (4) step(); line_active = 1'b0;
      rd(3'd0, d);
      chk(force_link && d == 16'h0002, "R9", "activity in link state ignored", int'(d), 2);

      // R8 abort in first window
      setup(2'd1, 2'd1, 16'd10, 1'b0);
      echo_peak = 1'b1; echo_sign = 1'b1; echo_loc = 10'd77;
      go_run(1'b1);
      repeat (5) step();
      line_active = 1'b1; step(); line_active = 1'b0;
      rd(3'd0, d); chk(d == 16'h0003, "R8", "done and fail after early activity", int'(d), 3);
      chk(verdict == 2'd3, "R8", "verdict after abort", int'(verdict), 3);
      rd(3'd4, d); chk(d == 16'h3000, "R8", "result empty after abort", int'(d), 16'h3000);
      repeat (100) step();
      chk(!force_link && tx_cy == 0, "R8", "no probe, no link after abort",
          int'(force_link) + tx_cy, 0);

      // R8 abort during probe
      setup(2'd0, 2'd1, 16'd50, 1'b0);
      go_run(1'b1);
      while (!tx_en) step();
      repeat (3) step();
      line_active = 1'b1; step(); line_active = 1'b0;
      chk(!tx_en, "R8", "probe stops on activity", int'(tx_en), 0);
      rd(3'd0, d); chk(d == 16'h0003, "R8", "done and fail after probe abort", int'(d), 3);
      repeat (60) step();
      chk(!force_link, "R8", "no link after probe abort", int'(force_link), 0);

      // random runs
      for (int i = 0; i < 6; i++) begin
         run(2'($urandom_range(3)), 2'($urandom_range(3)), 16'($urandom_range(300, 1)),
             1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(1)),
             10'($urandom_range(1023)), int'($urandom_range(100, 50)));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule